// File: doc/BRIEF.md
# Bus-Master Tenure Limiter

This block limits how long a bus-mastering agent may keep a shared parallel bus after it has won arbitration, so that bandwidth is spread fairly and no single master starves the others. Every agent able to master the bus carries one. When the agent takes ownership, a down-counter is loaded from an 8-bit software-programmed value. While the agent keeps the bus, the counter drops by one on each bus clock. When it reaches zero, the tenure is over.

After expiry the block asks the master's bus interface to hand the bus back, but only at the end of a data phase. It does not ask if the grant is still present and no other agent is requesting, because nobody is waiting. Once the master has let go, the block tells it when it may re-request straight away: the tenure has expired and no competitor is asking for the bus. The counter never wraps. It holds at zero until a new ownership event loads it again.

An ownership event is one cycle in which the grant is present, the bus is idle and the master starts a transaction. Ownership lasts while the master reports a transfer in progress. When that indication drops, for any reason, the count stops.

Top module: `bm_tenure_limiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `tenure_expired`, `release_req` and `regrab_ok` are 0, whatever state the block was in before.
- R2: An ownership event (`gnt`, `bus_idle` and `xfer_start` all 1 at a clock edge) loads `lat_cfg`. After that, `tenure_expired` rises after exactly `lat_cfg` further clock edges during which ownership continues with `xfer_busy` at 1.
- R3: An ownership event with `lat_cfg` equal to 0 sets `tenure_expired` at that same edge.
- R4: Ownership ends at the first edge after the event at which `xfer_busy` is 0. From then on the count does not advance, even if `xfer_busy` returns to 1, until the next ownership event.
- R5: Once set, `tenure_expired` stays at 1 until the next ownership event or reset, however many more busy cycles pass; the counter does not wrap.
- R6: `release_req` is 1 only while the agent owns the bus, the tenure has expired and `phase_end` is 1; with `phase_end` at 0 it is 0.
- R7: Under the R6 conditions, `release_req` is 0 when `gnt` is 1 and `others_req` is 0, and 1 when either `others_req` is 1 or `gnt` is 0.
- R8: `regrab_ok` is 1 exactly when the tenure has expired, the agent no longer owns the bus, and `others_req` is 0.
- R9: A new ownership event with a nonzero `lat_cfg` clears `tenure_expired` and restarts the count from the value present at that edge; later changes to `lat_cfg` during the tenure have no effect.
- R10: A cycle with `xfer_start` at 1 but `gnt` or `bus_idle` at 0 is not an ownership event and leaves `tenure_expired` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_cfg | input | CNT_W (8) | Software-programmed tenure length in bus clocks |
| gnt | input | 1 | Arbiter grant to this master |
| bus_idle | input | 1 | Shared bus is idle |
| xfer_start | input | 1 | Master begins a transaction this cycle |
| xfer_busy | input | 1 | Master has a transfer in progress (holds the bus) |
| phase_end | input | 1 | Current data phase completes this cycle |
| others_req | input | 1 | At least one other agent is requesting the bus |
| tenure_expired | output | 1 | Tenure counter has reached zero |
| release_req | output | 1 | Request to the bus interface to give the bus up now |
| regrab_ok | output | 1 | Master may re-request the bus at once |

## Verification
The properties assume that every input is a clean 0 or 1 at each rising edge and that reset is held low across the first edge. They also assume that `phase_end` is only meaningful while a transfer is running, so a release observed with `phase_end` at 1 is trusted to fall on a real phase boundary. The stimulus changes all inputs five nanoseconds after a rising edge and samples outputs at the same point, so the inputs are always settled when an edge arrives. The stimulus raises `phase_end` only inside an owned tenure, and it pulses `xfer_start` for exactly one cycle, so each ownership event is a single clean event.

// File: rtl/tenure_pkg.sv
package tenure_pkg;

  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_HOLD = 1'b1
  } own_state_e;

  typedef struct packed {
    logic gnt;
    logic bus_idle;
    logic xfer_start;
    logic xfer_busy;
  } bus_view_t;

endpackage

// File: rtl/tenure_own_track.sv
module tenure_own_track
  import tenure_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_view_t bus,
  output logic      own_start,
  output logic      owning,
  output logic      dec_en
);

  own_state_e state_q, state_d;

  // Ownership begins when granted, bus idle and a transaction launches.
  assign own_start = bus.gnt & bus.bus_idle & bus.xfer_start;

  always_comb begin
    state_d = state_q;
    if (own_start)
      state_d = OWN_HOLD;
    else if (state_q == OWN_HOLD && !bus.xfer_busy)
      state_d = OWN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= OWN_IDLE;
    else        state_q <= state_d;
  end

  assign owning = (state_q == OWN_HOLD);
  assign dec_en = owning & bus.xfer_busy;

endmodule

// File: rtl/tenure_down_cnt.sv
module tenure_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic         expired
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q;
  logic         exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      exp_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      exp_q <= (load_val == ZERO);
    end else if (dec_en && cnt_q != ZERO) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) exp_q <= 1'b1;
    end
  end

  assign expired = exp_q;

endmodule

// File: rtl/tenure_release_ctl.sv
module tenure_release_ctl (
  input  logic owning,
  input  logic expired,
  input  logic phase_end,
  input  logic gnt,
  input  logic others_req,
  output logic release_req,
  output logic regrab_ok
);

  logic nobody_waiting;

  // Keeping the grant with no competitor means no one needs the bus.
  assign nobody_waiting = gnt & ~others_req;

  assign release_req = owning & expired & phase_end & ~nobody_waiting;
  assign regrab_ok   = expired & ~owning & ~others_req;

endmodule

// File: rtl/bm_tenure_limiter.sv
module bm_tenure_limiter
  import tenure_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lat_cfg,
  input  logic             gnt,
  input  logic             bus_idle,
  input  logic             xfer_start,
  input  logic             xfer_busy,
  input  logic             phase_end,
  input  logic             others_req,
  output logic             tenure_expired,
  output logic             release_req,
  output logic             regrab_ok
);

  bus_view_t bus;
  logic      own_start;
  logic      owning;
  logic      dec_en;
  logic      expired;

  assign bus = '{gnt: gnt, bus_idle: bus_idle,
                 xfer_start: xfer_start, xfer_busy: xfer_busy};

  tenure_own_track u_own (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus       (bus),
    .own_start (own_start),
    .owning    (owning),
    .dec_en    (dec_en)
  );

  tenure_down_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (own_start),
    .load_val (lat_cfg),
    .dec_en   (dec_en),
    .expired  (expired)
  );

  tenure_release_ctl u_rel (
    .owning      (owning),
    .expired     (expired),
    .phase_end   (phase_end),
    .gnt         (gnt),
    .others_req  (others_req),
    .release_req (release_req),
    .regrab_ok   (regrab_ok)
  );

  assign tenure_expired = expired;

endmodule

// File: rtl/bm_tenure_limiter_chk.sv
module bm_tenure_limiter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] lat_cfg,
  input logic             gnt,
  input logic             bus_idle,
  input logic             xfer_start,
  input logic             xfer_busy,
  input logic             phase_end,
  input logic             others_req,
  input logic             tenure_expired,
  input logic             release_req,
  input logic             regrab_ok
);

  logic ev;
  assign ev = gnt & bus_idle & xfer_start;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!tenure_expired && !release_req && !regrab_ok));

  // R3
  zero_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && lat_cfg == '0) |=> tenure_expired);

  // R9
  reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && lat_cfg != '0) |=> !tenure_expired);

  // R5
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tenure_expired && !ev) |=> tenure_expired);

  // R6
  release_on_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_req |-> (phase_end && tenure_expired));

  // R7
  release_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_req |-> (others_req || !gnt));

  // R8
  regrab_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regrab_ok |-> (tenure_expired && !others_req && !release_req));

endmodule

bind bm_tenure_limiter bm_tenure_limiter_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/bm_tenure_limiter_tb_top.sv
module bm_tenure_limiter_tb_top;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] lat_cfg = '0;
  logic             gnt = 1'b0;
  logic             bus_idle = 1'b0;
  logic             xfer_start = 1'b0;
  logic             xfer_busy = 1'b0;
  logic             phase_end = 1'b0;
  logic             others_req = 1'b0;
  logic             tenure_expired;
  logic             release_req;
  logic             regrab_ok;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bm_tenure_limiter #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lat_cfg(lat_cfg), .gnt(gnt),
    .bus_idle(bus_idle), .xfer_start(xfer_start), .xfer_busy(xfer_busy),
    .phase_end(phase_end), .others_req(others_req),
    .tenure_expired(tenure_expired), .release_req(release_req),
    .regrab_ok(regrab_ok)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Advance to 5 ns after the next rising edge.
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  // One-cycle ownership event, then hold the bus busy.
  task automatic begin_tenure(input logic [CNT_W-1:0] cfg);
    lat_cfg = cfg; gnt = 1'b1; bus_idle = 1'b1; xfer_start = 1'b1; xfer_busy = 1'b0;
    step();
    xfer_start = 1'b0; bus_idle = 1'b0; xfer_busy = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(2);
    check("R1 expired in reset", tenure_expired, 1'b0);
    check("R1 release in reset", release_req, 1'b0);
    check("R1 regrab in reset", regrab_ok, 1'b0);
    rst_n = 1'b1; step();
    check("R1 expired after reset", tenure_expired, 1'b0);
  endtask

  task automatic t_count_release();
    others_req = 1'b1;
    begin_tenure(8'd5);
    check("R9 cleared at load", tenure_expired, 1'b0);
    step(4);
    check("R2 not yet expired", tenure_expired, 1'b0);
    step();
    check("R2 expired after 5", tenure_expired, 1'b1);
    step(300);
    check("R5 held without wrap", tenure_expired, 1'b1);
    phase_end = 1'b0; #1;
    check("R6 no release mid-phase", release_req, 1'b0);
    phase_end = 1'b1; #1;
    check("R6 release at phase end", release_req, 1'b1);
    others_req = 1'b0; #1;
    check("R7 suppressed: grant held, none waiting", release_req, 1'b0);
    gnt = 1'b0; #1;
    check("R7 release when grant removed", release_req, 1'b1);
    step();
    phase_end = 1'b0; xfer_busy = 1'b0;
    step();
    check("R8 regrab when idle and free", regrab_ok, 1'b1);
    check("R6 no release after ownership", release_req, 1'b0);
    others_req = 1'b1; #1;
    check("R8 no regrab with competitor", regrab_ok, 1'b0);
    others_req = 1'b0;
    gnt = 1'b0; bus_idle = 1'b1; xfer_start = 1'b1;
    step();
    check("R10 no event without grant", tenure_expired, 1'b1);
    gnt = 1'b1; bus_idle = 1'b0;
    step();
    check("R10 no event with bus busy", tenure_expired, 1'b1);
    xfer_start = 1'b0;
  endtask

  task automatic t_zero_cfg();
    begin_tenure(8'd0);
    check("R3 zero config expires at once", tenure_expired, 1'b1);
    xfer_busy = 1'b0; step();
  endtask

  task automatic t_lost_ownership();
    begin_tenure(8'd6);
    check("R9 expired cleared by new event", tenure_expired, 1'b0);
    step(3);
    xfer_busy = 1'b0; step();
    xfer_busy = 1'b1; step(10);
    check("R4 count frozen after loss", tenure_expired, 1'b0);
    xfer_busy = 1'b0; step();
    begin_tenure(8'd2);
    step();
    check("R9 reload not yet expired", tenure_expired, 1'b0);
    step();
    check("R9 reload expires after 2", tenure_expired, 1'b1);
    xfer_busy = 1'b0; step();
  endtask

  task automatic t_cfg_change();
    begin_tenure(8'd3);
    lat_cfg = 8'd200;
    step(2);
    check("R9 midway not expired", tenure_expired, 1'b0);
    step();
    check("R9 later cfg ignored", tenure_expired, 1'b1);
    others_req = 1'b1; phase_end = 1'b1;
    rst_n = 1'b0; step();
    check("R1 reset clears expired", tenure_expired, 1'b0);
    check("R1 reset drops release", release_req, 1'b0);
    rst_n = 1'b1; phase_end = 1'b0; xfer_busy = 1'b0; others_req = 1'b0;
    step();
  endtask

  initial begin
    step();
    t_reset();
    t_count_release();
    t_zero_cfg();
    t_lost_ownership();
    t_cfg_change();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule